// File: doc/BRIEF.md
# Quadrant-Banked Double-Buffered Input Reorder Buffer

This block sits in front of a column-oriented transform engine. It accepts one complex sample per cycle over a valid/ready stream. The samples of a frame arrive row by row, ROWS rows of COLS samples each. Each sample goes into one of four banks, chosen by the quarter of the row range that holds its row. Within its bank, a sample is placed so that a row's samples lie ROWS/4 words apart. Reading the banks with a plain incrementing address then gives the data back column by column, four words at a time, one word from each bank.

There are two complete frame buffers. While the engine reads one frame, the stream fills the other. When the write side completes a frame, the block raises a frame-ready flag. The write side stalls only when both buffers hold frames that have not been read. When the engine takes the last step of a frame, that buffer is released and the roles of the two buffers change.

Top module: `rbuf_top`

## Requirements
- R1: After reset, in_ready_o is 1, frame_ready_o is 0 and rd_valid_o is 0.
- R2: A sample in row r is delivered on read lane q = r / (ROWS/4). Lane q occupies bits [q*SW +: SW] of rd_data_o.
- R3: Read step s (0 .. ROWS*COLS/4-1) of a frame returns, on lane q, the sample at row q*(ROWS/4) + s mod (ROWS/4) and column s / (ROWS/4). Steps therefore walk one column at a time.
- R4: frame_ready_o is 1 in the cycle after the last sample of a frame is accepted. It stays 1 until the final read step of the frame being read.
- R5: A frame can be written into the free buffer while the other buffer is being read. Both frames are returned intact and in arrival order.
- R6: When both buffers hold unread frames, in_ready_o is 0, and samples offered with in_valid_i high are not stored.
- R7: rd_en_i has no effect while frame_ready_o is 0: rd_valid_o stays 0.
- R8: rd_valid_o is 1 in the cycle after each read step, which is a cycle with rd_en_i and frame_ready_o both high. rd_last_o marks the final step of the frame, and that step releases the buffer so that in_ready_o is 1 in the following cycle.
- R9: Cycles with in_valid_i low do not advance the write position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | SW | Complex input sample (real and imaginary packed) |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Buffer can accept a sample |
| frame_ready_o | output | 1 | A complete frame is available for reading |
| rd_en_i | input | 1 | Request one four-lane read step |
| rd_data_o | output | 4*SW | Four bank words, lane q at [q*SW +: SW] |
| rd_valid_o | output | 1 | rd_data_o holds a read result |
| rd_last_o | output | 1 | Result is the final step of the frame |

## Verification
A read result appears exactly one cycle after the rising edge that takes the read step, because the bank output register is the only stage on that path. frame_ready_o and in_ready_o change one edge after the final write or the final read. Inputs are driven on the falling edge and outputs are sampled on the following falling edge, so each check lands in the cycle where its result is due. A scoreboard queue holds the expected four-lane words in read order. The monitor compares each rd_valid_o cycle against the head of the queue, which also catches results that arrive early, late or are missing.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned LANE_W = $clog2(LANES);
endpackage

// File: rtl/rbuf_wr_gen.sv
module rbuf_wr_gen
  import rbuf_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 4,
  localparam int unsigned QR = ROWS / LANES,
  localparam int unsigned DEPTH = QR * COLS,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned CW = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  output logic [LANE_W-1:0] bank_o,
  output logic [AW-1:0]     addr_o,
  output logic              done_o
);
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic row_end, col_end;

  assign col_end = (int'(col_q) == COLS - 1);
  assign row_end = (int'(row_q) == ROWS - 1);
  assign done_o  = fire_i && col_end && row_end;

  // quadrant picks the bank; a row's samples sit QR words apart
  always_comb begin
    bank_o = LANE_W'(int'(row_q) / QR);
    addr_o = AW'(int'(col_q) * QR + int'(row_q) % QR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (fire_i) begin
      if (col_end) begin
        col_q <= '0;
        row_q <= row_end ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // R9
  no_idle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> ($stable(row_q) && $stable(col_q)));
  // R4
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (row_q == '0 && col_q == '0));
endmodule

// File: rtl/rbuf_bank.sv
module rbuf_bank #(
  parameter int unsigned SW = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          wsel_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [SW-1:0] wdata_i,
  input  logic          re_i,
  input  logic          rsel_i,
  input  logic [AW-1:0] raddr_i,
  output logic [SW-1:0] rdata_o
);
  logic [SW-1:0] mem_q [2*DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{wsel_i, waddr_i}] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[{rsel_i, raddr_i}];
  end
endmodule

// File: rtl/rbuf_rd_ctrl.sv
module rbuf_rd_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_step_o,
  output logic          valid_o,
  output logic          last_o
);
  logic [AW-1:0] cnt_q;

  assign addr_o      = cnt_q;
  assign last_step_o = (int'(cnt_q) == DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= step_i;
      last_o  <= step_i && last_step_o;
      if (step_i) cnt_q <= last_step_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R8
  last_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  // R3
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/rbuf_top.sv
module rbuf_top
  import rbuf_pkg::*;
#(
  parameter int unsigned SW = 16,
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              frame_ready_o,
  input  logic              rd_en_i,
  output logic [LANES*SW-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_last_o
);
  localparam int unsigned DEPTH = (ROWS / LANES) * COLS;
  localparam int unsigned AW = $clog2(DEPTH);

  logic [1:0] full_q;
  logic wr_sel_q, rd_sel_q;
  logic fire, wr_done, step, rd_done, rd_last_step;
  logic [LANE_W-1:0] wbank;
  logic [AW-1:0] waddr, raddr;

  assign in_ready_o    = !full_q[wr_sel_q];
  assign frame_ready_o = full_q[rd_sel_q];
  assign fire          = in_valid_i && in_ready_o;
  assign step          = rd_en_i && frame_ready_o;
  assign rd_done       = step && rd_last_step;

  rbuf_wr_gen #(.ROWS(ROWS), .COLS(COLS)) u_wr (
    .clk_i, .rst_ni, .fire_i(fire), .bank_o(wbank), .addr_o(waddr), .done_o(wr_done)
  );

  rbuf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni, .step_i(step), .addr_o(raddr), .last_step_o(rd_last_step),
    .valid_o(rd_valid_o), .last_o(rd_last_o)
  );

  for (genvar q = 0; q < LANES; q++) begin : g_bank
    rbuf_bank #(.SW(SW), .DEPTH(DEPTH)) u_bank (
      .clk_i, .rst_ni,
      .we_i(fire && (int'(wbank) == q)), .wsel_i(wr_sel_q), .waddr_i(waddr),
      .wdata_i(in_data_i),
      .re_i(step), .rsel_i(rd_sel_q), .raddr_i(raddr),
      .rdata_o(rd_data_o[q*SW +: SW])
    );
  end

  // write side only fills an empty buffer, read side only drains a full one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
    end else begin
      if (wr_done) begin
        full_q[wr_sel_q] <= 1'b1;
        wr_sel_q         <= !wr_sel_q;
      end
      if (rd_done) begin
        full_q[rd_sel_q] <= 1'b0;
        rd_sel_q         <= !rd_sel_q;
      end
    end
  end

  // R7
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !frame_ready_o) |=> !rd_valid_o);
  // R4
  frame_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> frame_ready_o);
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |=> (in_ready_o && rd_last_o));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> $stable(full_q) || $past(rd_done));
endmodule

// File: tb/sim_rbuf_top.sv
module sim_rbuf_top;
  localparam int SW = 16, ROWS = 8, COLS = 4, QR = ROWS / 4, DEPTH = QR * COLS;

  logic clk = 0, rst_n = 0;
  logic [SW-1:0] in_data = '0;
  logic in_valid = 0, rd_en = 0;
  logic in_ready, frame_ready, rd_valid, rd_last;
  logic [4*SW-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [4*SW:0] exp_q[$];

  always #5 clk = ~clk;

  rbuf_top #(.SW(SW), .ROWS(ROWS), .COLS(COLS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .frame_ready_o(frame_ready), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_last_o(rd_last)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] smp(input int f, input int r, input int c);
    return SW'((f << 8) | (r << 4) | c);
  endfunction

  // R2 R3: expected read order for one frame
  task automatic push_frame(input int f);
    for (int s = 0; s < DEPTH; s++) begin
      logic [4*SW-1:0] w;
      for (int q = 0; q < 4; q++) w[q*SW +: SW] = smp(f, q*QR + s % QR, s / QR);
      exp_q.push_back({(s == DEPTH-1), w});
    end
  endtask

  task automatic write_frame(input int f, input bit gaps, input bit check_flag);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        if (gaps && ((r + c) % 3 == 1)) begin  // R9 idle cycle
          in_valid = 0; in_data = 16'hdead;
          @(negedge clk);
        end
        in_valid = 1; in_data = smp(f, r, c);
        while (!in_ready) @(negedge clk);
        if (check_flag && r == ROWS-1 && c == COLS-1) chk("R4 before last", frame_ready, 0);
        @(posedge clk);
      end
    @(negedge clk);
    in_valid = 0;
    push_frame(f);
    if (check_flag) chk("R4 after last", frame_ready, 1);
  endtask

  task automatic read_frame();
    @(negedge clk);
    while (!frame_ready) @(negedge clk);
    for (int s = 0; s < DEPTH; s++) begin
      rd_en = 1;
      @(negedge clk);
      if (s == 3) begin rd_en = 0; @(negedge clk); end
    end
    rd_en = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_q.size() == 0) chk("R3 unexpected result", 1, 0);
    else begin
      logic [4*SW:0] e;
      e = exp_q.pop_front();
      chk("R3 R2 lanes", rd_data, e[4*SW-1:0]);
      chk("R8 last flag", rd_last, e[4*SW]);
    end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 frame_ready", frame_ready, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    // R7
    @(negedge clk); rd_en = 1;
    @(negedge clk); chk("R7 idle read", rd_valid, 0);
    @(negedge clk); chk("R7 idle read", rd_valid, 0); rd_en = 0;
    write_frame(0, 1, 1);
    write_frame(1, 0, 0);
    chk("R6 both full", in_ready, 0);
    // R6 offered samples while full
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_data = 16'hbeef;
      @(negedge clk);
      chk("R6 stall", in_ready, 0);
    end
    in_valid = 0;
    read_frame();
    @(negedge clk);
    chk("R8 released", in_ready, 1);
    chk("R4 next frame ready", frame_ready, 1);
    // R5 overlapped write and read
    fork
      write_frame(2, 1, 0);
      read_frame();
    join
    read_frame();
    repeat (3) @(negedge clk);
    chk("R8 drained", frame_ready, 0);
    chk("R5 queue empty", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule